// File: doc/BRIEF.md
# Merkle Branch Verification Engine

This block checks one leaf of a binary hash tree that protects eight contiguous data blocks stored in memory that cannot be trusted. The root of the tree is held only in an on-chip register and is never read from or written to memory. On a start command the engine computes the address of the chosen leaf. It reads the leaf, then reads the sibling node at each level going up, and folds the values together with a fixed mixing function until it has a recomputed root. It raises done with a pass flag that says whether the recomputed root matches the root register.

In write mode the same branch is first checked against the stored root. Only if that check succeeds does the engine compute a second chain from the new leaf value and the same siblings, write the new leaf and the new interior nodes back to memory, and load the new root into the register. The mixing function is a placeholder built from rotates, additions and XORs; it is not a cryptographic hash.

The memory side is a valid/ready request channel plus a response channel without back-pressure. The engine keeps a request valid, with address, direction and write data unchanged, until it sees ready high on a clock edge. The environment must return exactly one response per accepted read, at any later cycle. Writes receive no response. At most one read is outstanding at any time.

Top module: `mbv_engine`

## Requirements
- R1: After reset busy, done, pass and mreq_valid are all low.
- R2: Node k (root is -1 and is never stored; the children of k are 2k+2 and 2k+3) lives at byte address BASE + 4k. Leaf position p in 0..7 is node p+6. A check reads the leaf first. It then reads, from the bottom level upward, the sibling of the current path node: k+1 when k is even, k-1 when k is odd. The next path node is the parent, floor(k/2)-1.
- R3: At each level the running value is the right input of the mixing function when the current path node index is odd, and the left input when it is even. The mixing function is t = rotl(a,5)+b and h = t ^ rotl(t,13) ^ a ^ 0x9E3779B9, where a is the left input and b is the right.
- R4: done is high for exactly one cycle per command. pass is high in that cycle exactly when the recomputed root equals the root register, and pass keeps that value until the next accepted start.
- R5: In write mode with a passing check, the engine issues writes after the reads and issues no further reads. The writes go in this order: the new leaf at the leaf node, then each new interior node on the path from the bottom up. In the done cycle the root register takes the new root computed from the new leaf and the siblings that were read.
- R6: In write mode with a failing check, the engine issues no writes and leaves the root register unchanged.
- R7: While mreq_valid is high and mreq_ready is low, the request stays valid and its address, direction and write data stay unchanged into the next cycle. The engine waits for mrsp_valid before it issues the next request.
- R8: busy rises in the cycle after a start is accepted in idle and falls in the cycle after done. A start while busy has no effect.
- R9: root_load copies root_in into the root register only while the engine is idle. A root_load while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a command (accepted when idle) |
| wr_mode | input | 1 | 1 = check then update the branch, 0 = check only |
| leaf_pos | input | LEVELS | Leaf position within the tree |
| leaf_new | input | 32 | New leaf value for write mode |
| root_load | input | 1 | Load root_in into the root register (idle only) |
| root_in | input | 32 | Root value to load |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the branch check |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory accepts the request on this edge |
| mreq_we | output | 1 | 1 = write, 0 = read |
| mreq_addr | output | AW | Byte address of the node |
| mreq_wdata | output | 32 | Write data |
| mrsp_valid | input | 1 | Read data valid |
| mrsp_data | input | 32 | Read data |

## Verification
The first request appears in the cycle after start is sampled. Each following read appears in the cycle after the response to the previous read arrives. The first write comes two cycles after the last response, and each further write comes in the cycle after the previous write is accepted. done and the final pass value arrive one cycle after the last write is accepted, or two cycles after the last read response when no writes are issued. The bench memory responds one cycle after it accepts a read, and it drops ready on a fixed pattern so that stalls are covered. Every request is compared with the expected address, direction and data on the clock it is accepted. busy is compared on every clock with a model that rises after an accepted start and falls after done. pass and done are sampled only on the clocks where done is high and on the clock that follows.

// File: rtl/mbv_pkg.sv
package mbv_pkg;

  localparam int HW = 32;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RREQ,
    S_RWAIT,
    S_CHECK,
    S_WR,
    S_FIN
  } mbv_state_t;

  // Placeholder two-input mixer; a = left input, b = right input.
  function automatic logic [HW-1:0] mix32(input logic [HW-1:0] a, input logic [HW-1:0] b);
    logic [HW-1:0] t;
    t = {a[26:0], a[31:27]} + b;
    return t ^ {t[18:0], t[31:19]} ^ a ^ 32'h9E37_79B9;
  endfunction

endpackage

// File: rtl/mbv_path.sv
// Computes the node indices on the branch from a leaf up to a child of the root.
module mbv_path #(
  parameter int LEVELS = 3,
  parameter int IW     = LEVELS + 1
) (
  input  logic [LEVELS-1:0]         leaf,
  output logic [LEVELS-1:0][IW-1:0] node
);
  localparam logic [IW-1:0] FIRST_LEAF = IW'((1 << LEVELS) - 2);

  assign node[0] = FIRST_LEAF + IW'(leaf);

  for (genvar i = 0; i < LEVELS - 1; i++) begin : g_up
    assign node[i+1] = (node[i] >> 1) - IW'(1);
  end
endmodule

// File: rtl/mbv_hash_step.sv
// One level of recomputation: orders the running value and sibling, then mixes.
module mbv_hash_step (
  input  logic [31:0] cur,
  input  logic [31:0] sib,
  input  logic        cur_is_right,
  output logic [31:0] nxt
);
  import mbv_pkg::*;

  always_comb begin
    if (cur_is_right) nxt = mix32(sib, cur);
    else              nxt = mix32(cur, sib);
  end
endmodule

// File: rtl/mbv_engine.sv
module mbv_engine #(
  parameter int          LEVELS = 3,
  parameter int          AW     = 32,
  parameter logic [31:0] BASE   = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_mode,
  input  logic [LEVELS-1:0] leaf_pos,
  input  logic [31:0]       leaf_new,
  input  logic              root_load,
  input  logic [31:0]       root_in,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_we,
  output logic [AW-1:0]     mreq_addr,
  output logic [31:0]       mreq_wdata,
  input  logic              mrsp_valid,
  input  logic [31:0]       mrsp_data
);
  import mbv_pkg::*;

  localparam int IW = LEVELS + 1;
  localparam int CW = $clog2(LEVELS + 1);

  mbv_state_t        state;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     lvl;
  logic [LEVELS-1:0] leaf_q;
  logic              wr_q;
  logic [31:0]       cur_q;
  logic [31:0]       root_q;
  logic              pass_q;
  logic [31:0]       nval_q [0:LEVELS];

  logic [LEVELS-1:0][IW-1:0] path;
  logic [IW-1:0]             node_sel;
  logic [31:0]               h_old, h_new;
  logic                      root_match;

  mbv_path #(.LEVELS(LEVELS), .IW(IW)) u_path (
    .leaf (leaf_q),
    .node (path)
  );

  always_comb begin
    lvl = (cnt == '0) ? '0 : cnt - CW'(1);
  end

  mbv_hash_step u_old (
    .cur          (cur_q),
    .sib          (mrsp_data),
    .cur_is_right (path[lvl][0]),
    .nxt          (h_old)
  );

  mbv_hash_step u_new (
    .cur          (nval_q[lvl]),
    .sib          (mrsp_data),
    .cur_is_right (path[lvl][0]),
    .nxt          (h_new)
  );

  always_comb begin
    if (state == S_WR)   node_sel = path[cnt];
    else if (cnt == '0)  node_sel = path[0];
    else                 node_sel = path[lvl] ^ IW'(1);
  end

  assign root_match = (cur_q == root_q);
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FIN);
  assign pass       = pass_q;
  assign mreq_valid = (state == S_RREQ) || (state == S_WR);
  assign mreq_we    = (state == S_WR);
  assign mreq_addr  = BASE + (AW'(node_sel) << 2);
  assign mreq_wdata = (state == S_WR) ? nval_q[cnt] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      leaf_q <= '0;
      wr_q   <= 1'b0;
      cur_q  <= '0;
      root_q <= '0;
      pass_q <= 1'b0;
      for (int i = 0; i <= LEVELS; i++) nval_q[i] <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (root_load) root_q <= root_in;
          if (start) begin
            leaf_q    <= leaf_pos;
            wr_q      <= wr_mode;
            nval_q[0] <= leaf_new;
            pass_q    <= 1'b0;
            cnt       <= '0;
            state     <= S_RREQ;
          end
        end
        S_RREQ: if (mreq_ready) state <= S_RWAIT;
        S_RWAIT: begin
          if (mrsp_valid) begin
            if (cnt == '0) begin
              cur_q <= mrsp_data;
            end else begin
              cur_q       <= h_old;
              nval_q[cnt] <= h_new;
            end
            if (cnt == CW'(LEVELS)) begin
              state <= S_CHECK;
            end else begin
              cnt   <= cnt + CW'(1);
              state <= S_RREQ;
            end
          end
        end
        S_CHECK: begin
          pass_q <= root_match;
          if (wr_q && root_match) begin
            cnt   <= '0;
            state <= S_WR;
          end else begin
            state <= S_FIN;
          end
        end
        S_WR: begin
          if (mreq_ready) begin
            if (cnt == CW'(LEVELS - 1)) state <= S_FIN;
            else                        cnt   <= cnt + CW'(1);
          end
        end
        S_FIN: begin
          if (wr_q && pass_q) root_q <= nval_q[LEVELS];
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: a stalled request is held unchanged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) &&
                                     $stable(mreq_we) && $stable(mreq_wdata)));

  // R8: done only occurs while busy
  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R8: a start in idle makes the engine busy on the next cycle
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R9: the root register does not move during a command except at its end
  p_root_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(root_q));

  // R6: no write is issued unless the old branch matched
  p_no_write_on_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_we) |-> pass_q);

  // R4: done lasts a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_mbv_engine.sv
`timescale 1ns/1ps
module sim_mbv_engine;
  localparam int          L    = 3;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wr_mode = 1'b0, root_load = 1'b0;
  logic [L-1:0] leaf_pos = '0;
  logic [31:0] leaf_new = '0, root_in = '0;
  logic        busy, done, pass;
  logic        mreq_valid, mreq_we;
  logic        mreq_ready = 1'b0;
  logic [31:0] mreq_addr, mreq_wdata;
  logic        mrsp_valid = 1'b0;
  logic [31:0] mrsp_data = '0;

  always #10 clk = ~clk;

  mbv_engine #(.LEVELS(L), .AW(32), .BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode),
    .leaf_pos(leaf_pos), .leaf_new(leaf_new), .root_load(root_load),
    .root_in(root_in), .busy(busy), .done(done), .pass(pass),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_we(mreq_we),
    .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data)
  );

  logic [31:0] mem [0:13];
  logic [31:0] exp_root;
  logic [31:0] qa[$];
  logic [31:0] qd[$];
  bit          qw[$];
  int          nvec = 0, nerr = 0, cyc = 0;
  bit          mb = 1'b0, pend = 1'b0, stalled = 1'b0;
  logic [31:0] pend_d, stall_addr;

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] bh(logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    r = ((a << 5) | (a >> 27)) + b;
    return r ^ ((r << 13) | (r >> 19)) ^ a ^ 32'h9E37_79B9;
  endfunction

  function automatic int sib(int n);
    return (n % 2 == 0) ? n + 1 : n - 1;
  endfunction

  function automatic int par(int n);
    return (n % 2 == 0) ? (n - 2) / 2 : (n - 3) / 2;
  endfunction

  function automatic bit branch_ok(int p);
    int n = p + 6;
    logic [31:0] v = mem[n];
    for (int i = 0; i < L; i++) begin
      v = (n % 2 == 1) ? bh(mem[sib(n)], v) : bh(v, mem[sib(n)]);
      n = par(n);
    end
    return v == exp_root;
  endfunction

  // busy model: rises after an accepted start, falls after done
  always @(posedge clk) begin
    if (!rst_n)              mb <= 1'b0;
    else if (start && !mb)   mb <= 1'b1;
    else if (done)           mb <= 1'b0;
  end

  // memory model and per-clock comparison, away from the active edge
  always @(negedge clk) begin
    int idx;
    logic [31:0] a, d;
    bit w;
    cyc++;
    if (rst_n) chk(busy == mb, "R8 busy", 32'(busy), 32'(mb));
    if (rst_n && stalled)
      chk(mreq_valid && mreq_addr == stall_addr, "R7 held request", mreq_addr, stall_addr);
    mrsp_valid = pend;
    mrsp_data  = pend_d;
    pend       = 1'b0;
    mreq_ready = (cyc % 3 != 1);
    stalled    = rst_n && mreq_valid && !mreq_ready;
    stall_addr = mreq_addr;
    if (rst_n && mreq_valid && mreq_ready) begin
      if (qa.size() == 0) begin
        chk(1'b0, "R8 unexpected request", mreq_addr, 32'h0);
      end else begin
        a = qa.pop_front();
        w = qw.pop_front();
        d = qd.pop_front();
        chk(mreq_addr == a, "R2 address", mreq_addr, a);
        chk(mreq_we == w, "R5 direction", 32'(mreq_we), 32'(w));
        if (w) chk(mreq_wdata == d, "R5 write data", mreq_wdata, d);
      end
      idx = int'((mreq_addr - BASE) >> 2);
      if (idx >= 0 && idx < 14) begin
        if (mreq_we) mem[idx] = mreq_wdata;
        else begin
          pend   = 1'b1;
          pend_d = mem[idx];
        end
      end
    end
  end

  task automatic load_root(logic [31:0] v);
    @(negedge clk);
    root_load = 1'b1;
    root_in   = v;
    @(negedge clk);
    root_load = 1'b0;
  endtask

  task automatic run(int p, bit wr, logic [31:0] nl, bit disturb);
    bit ok;
    int n;
    logic [31:0] v, nroot;
    ok = branch_ok(p);
    n  = p + 6;
    qa.push_back(BASE + 32'(4 * n)); qw.push_back(1'b0); qd.push_back(32'h0);
    for (int i = 0; i < L; i++) begin
      qa.push_back(BASE + 32'(4 * sib(n))); qw.push_back(1'b0); qd.push_back(32'h0);
      n = par(n);
    end
    nroot = exp_root;
    if (wr && ok) begin
      n = p + 6;
      v = nl;
      for (int i = 0; i < L; i++) begin
        qa.push_back(BASE + 32'(4 * n)); qw.push_back(1'b1); qd.push_back(v);
        v = (n % 2 == 1) ? bh(mem[sib(n)], v) : bh(v, mem[sib(n)]);
        n = par(n);
      end
      nroot = v;
    end
    @(negedge clk);
    start = 1'b1; wr_mode = wr; leaf_pos = L'(p); leaf_new = nl;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (2) @(negedge clk);
      start = 1'b1; leaf_pos = L'(p ^ 1); root_load = 1'b1; root_in = ~exp_root;
      @(negedge clk);
      start = 1'b0; root_load = 1'b0;
    end
    while (!done) @(negedge clk);
    if (wr && !ok) chk(pass == 1'b0, "R6 failed update pass", 32'(pass), 32'(0));
    else           chk(pass == ok, "R3 R4 pass on done", 32'(pass), 32'(ok));
    chk(qa.size() == 0, "R2 missing request", 32'(qa.size()), 32'h0);
    qa.delete(); qw.delete(); qd.delete();
    exp_root = nroot;
    @(negedge clk);
    chk(done == 1'b0, "R4 done pulse width", 32'(done), 32'h0);
    chk(pass == ok, "R4 pass held", 32'(pass), 32'(ok));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[6 + i] = 32'hA500_0000 + 32'(i) * 32'h0101_0101;
    for (int k = 5; k >= 0; k--) mem[k] = bh(mem[2 * k + 2], mem[2 * k + 3]);
    exp_root = bh(mem[0], mem[1]);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 32'h0);
    chk(done == 1'b0, "R1 done", 32'(done), 32'h0);
    chk(pass == 1'b0, "R1 pass", 32'(pass), 32'h0);
    chk(mreq_valid == 1'b0, "R1 request", 32'(mreq_valid), 32'h0);

    load_root(exp_root);                        // R9 idle load
    for (int p = 0; p < 8; p++) run(p, 1'b0, 32'h0, 1'b0);   // R2 R3 R4

    mem[3] ^= 32'h1;                            // sibling on the path of leaf 0
    chk(branch_ok(0) == 1'b0, "R4 corrupted sibling setup", 32'h1, 32'h0);
    run(0, 1'b0, 32'h0, 1'b0);
    mem[3] ^= 32'h1;

    mem[9] ^= 32'h100;                          // leaf 3 itself
    run(3, 1'b0, 32'h0, 1'b0);
    mem[9] ^= 32'h100;

    run(5, 1'b1, 32'hDEAD_BEEF, 1'b0);          // R5 update
    for (int p = 0; p < 8; p++) run(p, 1'b0, 32'h0, 1'b0);

    mem[12] ^= 32'h2;                           // R6 failing update of leaf 7
    run(7, 1'b1, 32'h1234_5678, 1'b0);
    mem[12] ^= 32'h2;
    run(7, 1'b0, 32'h0, 1'b0);                  // R6 old root still valid

    run(2, 1'b0, 32'h0, 1'b1);                  // R8 R9 disturbance while busy
    run(2, 1'b0, 32'h0, 1'b0);
    run(3, 1'b0, 32'h0, 1'b0);

    load_root(exp_root ^ 32'h80);               // R9 wrong root loaded when idle
    exp_root = exp_root ^ 32'h80;
    run(4, 1'b0, 32'h0, 1'b0);
    exp_root = exp_root ^ 32'h80;
    load_root(exp_root);
    run(4, 1'b0, 32'h0, 1'b0);

    run(0, 1'b1, 32'h0BAD_F00D, 1'b0);          // R3 R5 update of leftmost leaf
    for (int p = 0; p < 8; p += 3) run(p, 1'b0, 32'h0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule